// File: doc/BRIEF.md
# Virtual Address Translator with Hardware Table Walk

This block turns virtual addresses from load, store and instruction-fetch requests into physical addresses. Pages are 4 KB. The low 12 bits of an address pass through unchanged as the page offset, and the upper bits form the virtual page number. A small fully associative translation cache holds recently used page-table entries. A request that hits in this cache is answered on the next cycle.

On a miss, a hardware walker computes the entry's address. That address is the page-table base plus the page number times four. The walker reads the entry through a memory request/response port and accepts any read latency. It then writes the entry back with the referenced flag set, and with the dirty flag also set when the access is a permitted store. If the access is allowed, the walker installs the translation in the cache. A missing translation is answered with a page-fault status, and a forbidden access with a protection-fault status. A physical address is returned only when neither fault applies.

Loading a new base value on a context switch also invalidates every cached translation. While the cache holds a page as clean, a store that hits that page writes the entry back with the dirty flag set. After that, the cached copy is marked dirty as well.

Top module: `xlt_mmu`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0. The translation cache is empty, so the first access to any page causes a walk.
- R2: The virtual page number is `req_vaddr[31:12]`. A walk issues exactly one read, at address base + page_number*4 (32-bit wrap). A successful response carries `rsp_paddr = {entry[31:12], req_vaddr[11:0]}`.
- R3: The entry word uses these fields: bit 0 valid, bit 1 read allowed, bit 2 write allowed, bit 3 execute allowed, bit 4 referenced, bit 5 dirty, bits 31:12 physical page number. Bits 11:6 are written back unchanged.
- R4: A request that hits an allowed, non-upgrading translation responds one cycle after acceptance with status 00 and causes no memory traffic. The response uses the cached copy even if the entry in memory has since changed.
- R5: For a walk that finds a valid entry, the walker writes the entry back once, with bit 4 set. This write comes after the read response and one cycle before the translation response.
- R6: An entry with bit 0 clear returns status 01 (page fault) and `rsp_paddr` 0. It produces no write and installs nothing, so a repeat access walks again.
- R7: The access kind selects the permission bit to check. Kind 00 (load) needs bit 1, kind 01 (store) needs bit 2, kind 10 (fetch) needs bit 3, and kind 11 is never allowed. A missing permission returns status 10 (protection fault) with `rsp_paddr` 0. On a hit this causes no memory traffic. On a walk the referenced write still happens, but nothing is installed.
- R8: A store that walks to a writable entry writes it back with bit 5 set. A store that hits a clean cached entry issues one write of the cached entry with bits 0, 4 and 5 set, responds two cycles after acceptance, and then treats the page as dirty. Later stores to that page cause no traffic.
- R9: The cache holds 8 translations. New translations replace entries in round-robin order. The replacement pointer starts at entry 0 after reset or a flush and advances once per install.
- R10: `ctx_load` loads `ctx_base` as the new table base and invalidates all cached translations. It also resets the replacement pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctx_load | input | 1 | Load a new table base and flush the cache |
| ctx_base | input | 32 | New page-table base address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 reserved |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 00 ok, 01 page fault, 10 protection fault |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| mem_req_valid | output | 1 | Memory access strobe, one cycle |
| mem_req_write | output | 1 | 1 for an entry write-back, 0 for a read |
| mem_req_addr | output | 32 | Entry address |
| mem_req_wdata | output | 32 | Entry word written back |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_rdata | input | 32 | Entry word read |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 4 KB pages and an 8-entry cache. The random phase spreads accesses over 16 pages, twice the cache size, so round-robin eviction, refills and re-walks of evicted pages happen often. It switches between two page tables at different base addresses, which exercises flushes and the base-plus-index address arithmetic. The memory model answers reads after a random delay of one to four cycles, which covers the walker's wait for variable latency.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

   // Fixed flag positions inside a page-table entry word
   localparam int PTE_V     = 0;
   localparam int PTE_RD    = 1;
   localparam int PTE_WR    = 2;
   localparam int PTE_EX    = 3;
   localparam int PTE_REF   = 4;
   localparam int PTE_DIRTY = 5;
   localparam int PTE_FLAGS = 6;

   // Response status codes
   localparam logic [1:0] ST_OK   = 2'b00;
   localparam logic [1:0] ST_PAGE = 2'b01;
   localparam logic [1:0] ST_PROT = 2'b10;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'b00,
      ACC_STORE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_e;

   typedef enum logic [1:0] {
      W_IDLE = 2'b00,
      W_RD   = 2'b01,
      W_WAIT = 2'b10,
      W_WB   = 2'b11
   } walk_st_e;

   typedef struct packed {
      logic x;
      logic w;
      logic r;
   } perm_t;

endpackage

// File: rtl/xlt_perm.sv
module xlt_perm
   import xlt_pkg::*;
(
   input  logic [1:0] kind,
   input  perm_t      perm,
   output logic       allowed
);

   always_comb begin
      case (kind)
         ACC_LOAD:  allowed = perm.r;
         ACC_STORE: allowed = perm.w;
         ACC_FETCH: allowed = perm.x;
         default:   allowed = 1'b0;
      endcase
   end

endmodule

// File: rtl/xlt_tlb.sv
module xlt_tlb
   import xlt_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        flush,
   input  logic [VPN_W-1:0]            lk_vpn,
   output logic                        lk_hit,
   output logic [$clog2(ENTRIES)-1:0]  lk_idx,
   output logic [PPN_W-1:0]            lk_ppn,
   output perm_t                       lk_perm,
   output logic                        lk_dirty,
   input  logic                        fill_en,
   input  logic [VPN_W-1:0]            fill_vpn,
   input  logic [PPN_W-1:0]            fill_ppn,
   input  perm_t                       fill_perm,
   input  logic                        fill_dirty,
   input  logic                        mark_en,
   input  logic [$clog2(ENTRIES)-1:0]  mark_idx
);

   localparam int  IDX_W = $clog2(ENTRIES);
   localparam bit  POW2  = ((ENTRIES & (ENTRIES - 1)) == 0);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("xlt_tlb: ENTRIES must be at least 2");
   end

   logic [ENTRIES-1:0] ent_v;
   logic [ENTRIES-1:0] ent_d;
   logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
   logic [PPN_W-1:0]   ent_ppn  [ENTRIES];
   perm_t              ent_perm [ENTRIES];
   logic [ENTRIES-1:0] hit_vec;
   logic [IDX_W-1:0]   rr_q;
   logic [IDX_W-1:0]   rr_next;

   // Parallel tag compare, one comparator per entry
   for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
      assign hit_vec[gi] = ent_v[gi] && (ent_vpn[gi] == lk_vpn);
   end

   // Replacement pointer advance: natural wrap for powers of two
   if (POW2) begin : g_rr_wrap
      assign rr_next = rr_q + 1'b1;
   end else begin : g_rr_cmp
      assign rr_next = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
   end

   always_comb begin
      lk_ppn   = '0;
      lk_perm  = '0;
      lk_dirty = 1'b0;
      lk_idx   = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) begin
            lk_ppn   = lk_ppn | ent_ppn[i];
            lk_perm  = lk_perm | ent_perm[i];
            lk_dirty = lk_dirty | ent_d[i];
            lk_idx   = lk_idx | IDX_W'(i);
         end
      end
   end
   assign lk_hit = |hit_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_v <= '0;
         ent_d <= '0;
         rr_q  <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            ent_vpn[i]  <= '0;
            ent_ppn[i]  <= '0;
            ent_perm[i] <= '0;
         end
      end else if (flush) begin
         ent_v <= '0;
         rr_q  <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (fill_en && rr_q == IDX_W'(i)) begin
               ent_v[i]    <= 1'b1;
               ent_d[i]    <= fill_dirty;
               ent_vpn[i]  <= fill_vpn;
               ent_ppn[i]  <= fill_ppn;
               ent_perm[i] <= fill_perm;
            end else if (mark_en && mark_idx == IDX_W'(i)) begin
               ent_d[i] <= 1'b1;
            end
         end
         if (fill_en) rr_q <= rr_next;
      end
   end

   p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (ent_v == '0))
      else $error("flush left a valid entry");

   p_single_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec))
      else $error("more than one entry matched");

   p_fill_after_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |-> !(lk_hit && lk_vpn == fill_vpn))
      else $error("fill of a page already cached");

endmodule

// File: rtl/xlt_mmu.sv
module xlt_mmu
   import xlt_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int PTE_W       = 32,
   parameter int PAGE_BITS   = 12,
   parameter int TLB_ENTRIES = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctx_load,
   input  logic [PTE_W-1:0]  ctx_base,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic [1:0]        req_kind,
   output logic              rsp_valid,
   output logic [1:0]        rsp_status,
   output logic [PTE_W-1:0]  rsp_paddr,
   output logic              mem_req_valid,
   output logic              mem_req_write,
   output logic [PTE_W-1:0]  mem_req_addr,
   output logic [PTE_W-1:0]  mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [PTE_W-1:0]  mem_rsp_rdata
);

   localparam int VPN_W     = VA_W - PAGE_BITS;
   localparam int PPN_W     = PTE_W - PAGE_BITS;
   localparam int PTE_BYTES = PTE_W / 8;
   localparam int PTE_SHIFT = $clog2(PTE_BYTES);
   localparam int IDX_W     = $clog2(TLB_ENTRIES);

   if (PAGE_BITS < PTE_FLAGS) begin : g_bad_page
      $error("xlt_mmu: page offset too narrow for entry flags");
   end
   if (VA_W <= PAGE_BITS) begin : g_bad_va
      $error("xlt_mmu: virtual address narrower than page offset");
   end
   if ((PTE_W % 8) != 0 || (PTE_BYTES & (PTE_BYTES - 1)) != 0) begin : g_bad_pte
      $error("xlt_mmu: entry width must be a power-of-two byte count");
   end

   walk_st_e            st_q;
   logic [PTE_W-1:0]    base_q;
   logic [VPN_W-1:0]    cur_vpn_q;
   logic [PAGE_BITS-1:0] cur_off_q;
   logic [1:0]          cur_kind_q;
   logic [PTE_W-1:0]    pte_addr_q;
   logic [PTE_W-1:0]    wb_word_q;
   logic                install_q;
   logic                mark_q;
   logic [IDX_W-1:0]    mark_idx_q;
   logic [1:0]          pend_status_q;
   logic [PTE_W-1:0]    pend_paddr_q;
   logic                rsp_valid_q;
   logic [1:0]          rsp_status_q;
   logic [PTE_W-1:0]    rsp_paddr_q;

   logic [VPN_W-1:0]     req_vpn;
   logic [PAGE_BITS-1:0] req_off;
   logic                 lk_hit;
   logic [IDX_W-1:0]     lk_idx;
   logic [PPN_W-1:0]     lk_ppn;
   perm_t                lk_perm;
   logic                 lk_dirty;
   logic                 hit_ok;
   logic                 pte_ok;
   perm_t                rd_perm;
   perm_t                wb_perm;
   logic [PTE_W-1:0]     walk_word;

   assign req_vpn = req_vaddr[VA_W-1:PAGE_BITS];
   assign req_off = req_vaddr[PAGE_BITS-1:0];

   assign rd_perm = '{x: mem_rsp_rdata[PTE_EX], w: mem_rsp_rdata[PTE_WR], r: mem_rsp_rdata[PTE_RD]};
   assign wb_perm = '{x: wb_word_q[PTE_EX], w: wb_word_q[PTE_WR], r: wb_word_q[PTE_RD]};

   function automatic logic [PTE_W-1:0] pack_entry(input logic [PPN_W-1:0] ppn,
                                                   input perm_t p);
      logic [PTE_W-1:0] w;
      w = '0;
      w[PTE_W-1:PAGE_BITS] = ppn;
      w[PTE_V]     = 1'b1;
      w[PTE_RD]    = p.r;
      w[PTE_WR]    = p.w;
      w[PTE_EX]    = p.x;
      w[PTE_REF]   = 1'b1;
      w[PTE_DIRTY] = 1'b1;
      return w;
   endfunction

   // Entry word written back after a walk: referenced always, dirty on a permitted store
   always_comb begin
      walk_word = mem_rsp_rdata;
      walk_word[PTE_REF] = 1'b1;
      if (cur_kind_q == ACC_STORE && mem_rsp_rdata[PTE_WR])
         walk_word[PTE_DIRTY] = 1'b1;
   end

   xlt_tlb #(
      .ENTRIES (TLB_ENTRIES),
      .VPN_W   (VPN_W),
      .PPN_W   (PPN_W)
   ) u_tlb (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (ctx_load),
      .lk_vpn     (req_vpn),
      .lk_hit     (lk_hit),
      .lk_idx     (lk_idx),
      .lk_ppn     (lk_ppn),
      .lk_perm    (lk_perm),
      .lk_dirty   (lk_dirty),
      .fill_en    (st_q == W_WB && install_q),
      .fill_vpn   (cur_vpn_q),
      .fill_ppn   (wb_word_q[PTE_W-1:PAGE_BITS]),
      .fill_perm  (wb_perm),
      .fill_dirty (wb_word_q[PTE_DIRTY]),
      .mark_en    (st_q == W_WB && mark_q),
      .mark_idx   (mark_idx_q)
   );

   xlt_perm u_hit_perm (
      .kind    (req_kind),
      .perm    (lk_perm),
      .allowed (hit_ok)
   );

   xlt_perm u_walk_perm (
      .kind    (cur_kind_q),
      .perm    (rd_perm),
      .allowed (pte_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q          <= W_IDLE;
         base_q        <= '0;
         cur_vpn_q     <= '0;
         cur_off_q     <= '0;
         cur_kind_q    <= '0;
         pte_addr_q    <= '0;
         wb_word_q     <= '0;
         install_q     <= 1'b0;
         mark_q        <= 1'b0;
         mark_idx_q    <= '0;
         pend_status_q <= ST_OK;
         pend_paddr_q  <= '0;
         rsp_valid_q   <= 1'b0;
         rsp_status_q  <= ST_OK;
         rsp_paddr_q   <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         if (ctx_load) base_q <= ctx_base;
         case (st_q)
            W_IDLE: begin
               if (req_valid) begin
                  cur_vpn_q  <= req_vpn;
                  cur_off_q  <= req_off;
                  cur_kind_q <= req_kind;
                  pte_addr_q <= base_q + (PTE_W'(req_vpn) << PTE_SHIFT);
                  install_q  <= 1'b0;
                  mark_q     <= 1'b0;
                  if (!lk_hit) begin
                     st_q <= W_RD;
                  end else if (!hit_ok) begin
                     rsp_valid_q  <= 1'b1;
                     rsp_status_q <= ST_PROT;
                     rsp_paddr_q  <= '0;
                  end else if (req_kind == ACC_STORE && !lk_dirty) begin
                     wb_word_q     <= pack_entry(lk_ppn, lk_perm);
                     mark_q        <= 1'b1;
                     mark_idx_q    <= lk_idx;
                     pend_status_q <= ST_OK;
                     pend_paddr_q  <= {lk_ppn, req_off};
                     st_q          <= W_WB;
                  end else begin
                     rsp_valid_q  <= 1'b1;
                     rsp_status_q <= ST_OK;
                     rsp_paddr_q  <= {lk_ppn, req_off};
                  end
               end
            end
            W_RD: st_q <= W_WAIT;
            W_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!mem_rsp_rdata[PTE_V]) begin
                     rsp_valid_q  <= 1'b1;
                     rsp_status_q <= ST_PAGE;
                     rsp_paddr_q  <= '0;
                     st_q         <= W_IDLE;
                  end else begin
                     wb_word_q     <= walk_word;
                     install_q     <= pte_ok;
                     pend_status_q <= pte_ok ? ST_OK : ST_PROT;
                     pend_paddr_q  <= pte_ok ? {mem_rsp_rdata[PTE_W-1:PAGE_BITS], cur_off_q} : '0;
                     st_q          <= W_WB;
                  end
               end
            end
            W_WB: begin
               rsp_valid_q  <= 1'b1;
               rsp_status_q <= pend_status_q;
               rsp_paddr_q  <= pend_paddr_q;
               st_q         <= W_IDLE;
            end
            default: st_q <= W_IDLE;
         endcase
      end
   end

   assign req_ready     = (st_q == W_IDLE);
   assign rsp_valid     = rsp_valid_q;
   assign rsp_status    = rsp_status_q;
   assign rsp_paddr     = rsp_paddr_q;
   assign mem_req_valid = (st_q == W_RD) || (st_q == W_WB);
   assign mem_req_write = (st_q == W_WB);
   assign mem_req_addr  = pte_addr_q;
   assign mem_req_wdata = wb_word_q;

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req_valid)
      else $error("memory access while idle");

   p_fault_no_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status != ST_OK) |-> (rsp_paddr == '0))
      else $error("fault response carries an address");

   p_wb_sets_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write) |-> (mem_req_wdata[PTE_REF] && mem_req_wdata[PTE_V]))
      else $error("write-back without referenced flag");

   p_read_then_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_write) |=> (!mem_req_valid && !rsp_valid))
      else $error("activity right after a table read");

   p_wb_then_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write) |=> rsp_valid)
      else $error("no response after a write-back");

endmodule

// File: tb/xlt_mmu_test.sv
module xlt_mmu_test;
   import xlt_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctx_load = 1'b0;
   logic [31:0] ctx_base = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic        rsp_valid;
   logic [1:0]  rsp_status;
   logic [31:0] rsp_paddr;
   logic        mem_req_valid;
   logic        mem_req_write;
   logic [31:0] mem_req_addr;
   logic [31:0] mem_req_wdata;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_rdata = '0;

   always #10 clk = ~clk;

   xlt_mmu uut (
      .clk(clk), .rst_n(rst_n), .ctx_load(ctx_load), .ctx_base(ctx_base),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_kind(req_kind),
      .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_paddr(rsp_paddr),
      .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
   );

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Memory model and golden page-table image
   logic [31:0] pmem [2048];
   logic [31:0] gpt  [2048];
   int          rd_cnt = 0;
   int          wr_cnt = 0;
   logic [31:0] last_rd = '0;
   bit          pend = 1'b0;
   int          lat = 0;
   logic [31:0] pend_addr = '0;

   function automatic int widx(input logic [31:0] a);
      return int'(a[12:2]);
   endfunction

   always @(negedge clk) begin
      mem_rsp_valid = 1'b0;
      if (pend) begin
         if (lat == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_rdata = pmem[widx(pend_addr)];
            pend = 1'b0;
         end else lat--;
      end
      if (mem_req_valid) begin
         if (mem_req_write) begin
            pmem[widx(mem_req_addr)] = mem_req_wdata;
            wr_cnt++;
         end else begin
            rd_cnt++;
            last_rd   = mem_req_addr;
            pend_addr = mem_req_addr;
            pend      = 1'b1;
            lat       = int'($urandom_range(0, 3));
         end
      end
   end

   // Reference translation cache
   logic        mv    [8];
   logic [19:0] mvpn  [8];
   logic [19:0] mppn  [8];
   logic [2:0]  mperm [8];   // {x, w, r}
   logic        md    [8];
   int          mptr = 0;
   logic [31:0] base_cur = '0;

   task automatic flush_model();
      for (int i = 0; i < 8; i++) mv[i] = 1'b0;
      mptr = 0;
   endtask

   function automatic bit allowed(input logic [1:0] k, input logic r, input logic w, input logic x);
      case (k)
         2'b00:   return r;
         2'b01:   return w;
         2'b10:   return x;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [31:0] mk_pte(input logic [19:0] ppn, input logic v, input logic r,
                                          input logic w, input logic x, input logic d);
      return {ppn, 6'b0, d, 1'b0, x, w, r, v};
   endfunction

   task automatic set_pte(input logic [31:0] base, input int vpn, input logic [31:0] word);
      int ix;
      ix = widx(base + 32'(vpn * 4));
      pmem[ix] = word;
      gpt[ix]  = word;
   endtask

   task automatic ctx_sw(input logic [31:0] b);
      @(negedge clk);
      ctx_load = 1'b1;
      ctx_base = b;
      @(negedge clk);
      ctx_load = 1'b0;
      base_cur = b;
      flush_model();
   endtask

   task automatic access(input logic [1:0] kind, input logic [19:0] vpn, input logic [11:0] off,
                         input string tag);
      logic [31:0] paddr_ent;
      logic [31:0] w;
      int          ix, hi, cyc, rd0, wr0, exp_rd, exp_wr;
      logic [1:0]  exp_st;
      logic [31:0] exp_pa;
      bit          clean_hit, upg_hit;
      paddr_ent = base_cur + {10'b0, vpn, 2'b00};
      ix = widx(paddr_ent);
      hi = -1;
      clean_hit = 1'b0;
      upg_hit = 1'b0;
      exp_wr = 0;
      for (int i = 0; i < 8; i++) if (mv[i] && mvpn[i] == vpn) hi = i;
      if (hi >= 0) begin
         exp_rd = 0;
         if (!allowed(kind, mperm[hi][0], mperm[hi][1], mperm[hi][2])) begin
            exp_st = ST_PROT; exp_pa = '0;
         end else begin
            exp_st = ST_OK; exp_pa = {mppn[hi], off};
            if (kind == 2'b01 && !md[hi]) begin
               exp_wr = 1; upg_hit = 1'b1;
               gpt[ix] = mk_pte(mppn[hi], 1'b1, mperm[hi][0], mperm[hi][1], mperm[hi][2], 1'b1) | 32'h10;
               md[hi] = 1'b1;
            end else clean_hit = 1'b1;
         end
      end else begin
         exp_rd = 1;
         w = gpt[ix];
         if (!w[0]) begin
            exp_st = ST_PAGE; exp_pa = '0;
         end else begin
            w[4] = 1'b1;
            if (kind == 2'b01 && w[2]) w[5] = 1'b1;
            gpt[ix] = w;
            exp_wr = 1;
            if (allowed(kind, w[1], w[2], w[3])) begin
               exp_st = ST_OK; exp_pa = {w[31:12], off};
               mv[mptr] = 1'b1; mvpn[mptr] = vpn; mppn[mptr] = w[31:12];
               mperm[mptr] = {w[3], w[2], w[1]}; md[mptr] = w[5];
               mptr = (mptr + 1) % 8;
            end else begin
               exp_st = ST_PROT; exp_pa = '0;
            end
         end
      end
      rd0 = rd_cnt;
      wr0 = wr_cnt;
      @(negedge clk);
      chk("R1", "ready before request", {31'b0, req_ready}, 32'd1);
      req_valid = 1'b1;
      req_vaddr = {vpn, off};
      req_kind  = kind;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 1;
      while (!rsp_valid && cyc < 200) begin
         @(negedge clk);
         cyc++;
      end
      #1;
      chk(tag, "response seen", {31'b0, rsp_valid}, 32'd1);
      chk(tag, "status", {30'b0, rsp_status}, {30'b0, exp_st});
      chk(tag, "paddr", rsp_paddr, exp_pa);
      chk("R5", "table reads", 32'(rd_cnt - rd0), 32'(exp_rd));
      chk("R8", "table writes", 32'(wr_cnt - wr0), 32'(exp_wr));
      chk("R3", "entry in memory", pmem[ix], gpt[ix]);
      if (exp_rd == 1) chk("R2", "entry address", last_rd, paddr_ent);
      if (clean_hit) chk("R4", "hit latency", 32'(cyc), 32'd1);
      if (upg_hit) chk("R8", "dirty upgrade latency", 32'(cyc), 32'd2);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] b0, b1;
      void'($urandom(32'h5eed_1234));
      b0 = 32'h0000_1000;
      b1 = 32'h0000_1400;
      for (int i = 0; i < 2048; i++) begin
         pmem[i] = '0;
         gpt[i]  = '0;
      end
      for (int t = 0; t < 2; t++) begin
         for (int v = 0; v < 256; v++) begin
            set_pte(t == 0 ? b0 : b1, v,
                    mk_pte(20'($urandom), ($urandom % 8) != 0, 1'($urandom), 1'($urandom),
                           1'($urandom), ($urandom % 4) == 0));
         end
      end
      flush_model();

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle outputs after reset
      chk("R1", "ready after reset", {31'b0, req_ready}, 32'd1);
      chk("R1", "no response after reset", {31'b0, rsp_valid}, 32'd0);
      chk("R1", "no memory access after reset", {31'b0, mem_req_valid}, 32'd0);

      // Base register loads as zero after reset; set table 0
      ctx_sw(b0);

      set_pte(b0, 100, mk_pte(20'hABCDE, 1, 1, 0, 0, 0));
      access(2'b00, 20'd100, 12'h123, "R5");      // miss, walk, install
      access(2'b00, 20'd100, 12'hFFF, "R4");      // hit
      access(2'b01, 20'd100, 12'h004, "R7");      // store without write right, hit
      access(2'b11, 20'd100, 12'h000, "R7");      // reserved kind

      set_pte(b0, 101, mk_pte(20'h12345, 1, 1, 1, 0, 0));
      access(2'b01, 20'd101, 12'h010, "R8");      // store miss sets dirty
      access(2'b01, 20'd101, 12'h014, "R8");      // already dirty: no traffic

      set_pte(b0, 102, mk_pte(20'h0F0F0, 1, 1, 1, 1, 0));
      access(2'b00, 20'd102, 12'h020, "R5");
      access(2'b01, 20'd102, 12'h024, "R8");      // clean hit store upgrade
      access(2'b01, 20'd102, 12'h028, "R8");

      set_pte(b0, 103, mk_pte(20'h55555, 0, 1, 1, 1, 0));
      access(2'b00, 20'd103, 12'h000, "R6");
      access(2'b00, 20'd103, 12'h000, "R6");      // walks again

      set_pte(b0, 104, mk_pte(20'h77777, 1, 1, 0, 0, 0));
      access(2'b10, 20'd104, 12'h100, "R7");      // walk protection fault
      access(2'b10, 20'd104, 12'h100, "R7");      // not installed

      // R4: cached copy used after memory changes
      set_pte(b0, 100, mk_pte(20'h99999, 1, 1, 0, 0, 0));
      access(2'b00, 20'd100, 12'h456, "R4");
      // R10: flush makes the new entry visible
      ctx_sw(b0);
      access(2'b00, 20'd100, 12'h456, "R10");

      // R9: round-robin eviction
      ctx_sw(b0);
      for (int v = 105; v < 114; v++) set_pte(b0, v, mk_pte(20'(v * 7), 1, 1, 0, 0, 0));
      for (int v = 105; v < 113; v++) access(2'b00, 20'(v), 12'h0, "R9");
      access(2'b00, 20'd105, 12'h0, "R9");        // still cached
      access(2'b00, 20'd113, 12'h0, "R9");        // evicts the oldest
      access(2'b00, 20'd105, 12'h0, "R9");        // walks again
      access(2'b00, 20'd107, 12'h0, "R9");

      // R10 with a second table base; R2 address arithmetic
      ctx_sw(b1);
      access(2'b00, 20'd100, 12'h321, "R10");

      for (int n = 0; n < 400; n++) begin
         if (($urandom % 40) == 0) ctx_sw((($urandom % 2) == 0) ? b0 : b1);
         access(2'($urandom), 20'($urandom % 16), 12'($urandom), "R2");
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule